// File: doc/BRIEF.md
# Two-Stage In-Order Core

This block is a small in-order processor split into a front stage and a back stage joined by a single-entry slot. The front stage presents the program counter to an instruction memory, and it decodes the returned word. It reads the source registers and latches a decoded entry, including operand values, into the slot. The back stage consumes the slot in the following cycle. It adds, tests a register for zero to redirect the program counter, loads from data memory or stores to data memory. Both memories answer combinationally within the cycle.

Within one cycle the back stage is ordered ahead of the front stage. The slot is emptied and refilled in the same cycle. A register result produced by the back stage is seen by the operand read of the instruction being decoded in that cycle. A straight-line program therefore retires one instruction every cycle. A taken branch overrides the front stage. The word fetched in that cycle is thrown away, and the program counter is loaded with the branch target. The parameter `FWD` selects the bypass. With the default value of 1 the front stage never waits. With 0 the front stage reads the register file without the bypass and holds back an instruction whose source is still pending in the slot.

Top module: `core2_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `imem_addr` is 0 and `dmem_we` is 0. All eight 16-bit registers read as zero after reset.
- R2: An instruction word has its kind in bits [15:14]: 00 add, 01 branch-if-zero, 10 load, 11 store. Add writes rd = rs1 + rs2 modulo 2^16, with rd in [13:11], rs1 in [10:8] and rs2 in [7:5].
- R3: Load (rd [13:11], address register [10:8]) writes rd with the data memory word at the low 8 bits of the address register. Store (value register [13:11], address register [10:8]) raises `dmem_we` for one cycle, in the cycle after the store is fetched, with that address and value.
- R4: Branch-if-zero (condition register [13:11], target [7:0]) is taken when the condition register is zero. In the cycle after the branch is executed, `imem_addr` equals the target.
- R5: A branch-if-zero whose condition register is non-zero has no effect, and fetch continues at the next sequential address.
- R6: Absent a taken branch, `imem_addr` advances by one every cycle, so straight-line code completes one instruction per cycle.
- R7: An instruction that reads a register written by the instruction fetched just before it, whether an add or a load, gets the new value without delay.
- R8: The instruction fetched in the cycle a taken branch executes is discarded and changes no register or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction memory address (program counter) |
| imem_data | input | 16 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 8 | Data memory address for load and store |
| dmem_we | output | 1 | Data memory write enable |
| dmem_wdata | output | 16 | Data memory write value |
| dmem_rdata | input | 16 | Data memory word at `dmem_addr`, same cycle |

## Verification
Two functions can fall in the same cycle: the back stage draining the slot and the front stage refilling it. A taken branch and a fetch can also coincide. Programs chain each add or load straight into a consumer, including a store whose address and value both come from the previous result, and the final memory contents show whether the same-cycle bypass worked. The cycle-by-cycle address trace shows that the slot was refilled on every cycle. Branches are placed so that the killed fetch would, if it survived, corrupt a value that is later stored, and the trace must jump to the target exactly one cycle after the branch executes.

// File: rtl/core2_pkg.sv
package core2_pkg;

    localparam int XLEN    = 16;
    localparam int NREGS   = 8;
    localparam int RIDX_W  = $clog2(NREGS);
    localparam int PC_W    = 8;
    localparam int DADDR_W = 8;
    localparam int ILEN    = 16;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_BZ  = 2'b01,
        OP_LD  = 2'b10,
        OP_ST  = 2'b11
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] src_b;
        logic              wr;
        logic [PC_W-1:0]   tgt;
    } dec_t;

    typedef struct packed {
        logic              valid;
        op_e               op;
        logic              wr;
        logic [RIDX_W-1:0] dst;
        logic [XLEN-1:0]   a;
        logic [XLEN-1:0]   b;
        logic [PC_W-1:0]   tgt;
    } slot_t;

    function automatic dec_t decode(input logic [ILEN-1:0] w);
        dec_t d;
        d.op    = op_e'(w[15:14]);
        d.dst   = w[13:11];
        d.tgt   = w[PC_W-1:0];
        d.wr    = (d.op == OP_ADD) || (d.op == OP_LD);
        d.src_a = (d.op == OP_ADD) ? w[10:8] : w[13:11];
        d.src_b = (d.op == OP_ADD) ? w[7:5]  : w[10:8];
        return d;
    endfunction

    function automatic logic reads_a(input op_e op);
        return op != OP_LD;
    endfunction

    function automatic logic reads_b(input op_e op);
        return op != OP_BZ;
    endfunction

endpackage

// File: rtl/core2_regfile.sv
module core2_regfile
    import core2_pkg::*;
#(
    parameter bit FWD = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [RIDX_W-1:0] raddr_a,
    input  logic [RIDX_W-1:0] raddr_b,
    output logic [XLEN-1:0]   rdata_a,
    output logic [XLEN-1:0]   rdata_b
);

    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    generate
        if (FWD) begin : g_wr_first
            // the write of this cycle is seen by the read of this cycle
            always_comb begin
                rdata_a = (we && waddr == raddr_a) ? wdata : regs[raddr_a];
                rdata_b = (we && waddr == raddr_b) ? wdata : regs[raddr_b];
            end
        end else begin : g_rd_first
            always_comb begin
                rdata_a = regs[raddr_a];
                rdata_b = regs[raddr_b];
            end
        end
    endgenerate

endmodule

// File: rtl/core2_front.sv
module core2_front
    import core2_pkg::*;
#(
    parameter bit FWD = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ILEN-1:0]   instr,
    input  logic              redirect,
    input  logic [PC_W-1:0]   redirect_pc,
    input  logic [XLEN-1:0]   rdata_a,
    input  logic [XLEN-1:0]   rdata_b,
    output logic [RIDX_W-1:0] raddr_a,
    output logic [RIDX_W-1:0] raddr_b,
    output logic [PC_W-1:0]   pc,
    output logic              stall,
    output slot_t             slot
);

    dec_t dec;

    always_comb begin
        dec     = decode(instr);
        raddr_a = dec.src_a;
        raddr_b = dec.src_b;
    end

    generate
        if (FWD) begin : g_no_hazard
            // the pending entry retires and is bypassed this cycle
            assign stall = 1'b0;
        end else begin : g_hazard
            always_comb begin
                stall = slot.valid && slot.wr &&
                        ((reads_a(dec.op) && dec.src_a == slot.dst) ||
                         (reads_b(dec.op) && dec.src_b == slot.dst));
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= '0;
            slot <= '0;
        end else if (redirect) begin
            pc   <= redirect_pc;
            slot <= '0;
        end else if (stall) begin
            slot <= '0;
        end else begin
            pc         <= pc + 1'b1;
            slot.valid <= 1'b1;
            slot.op    <= dec.op;
            slot.wr    <= dec.wr;
            slot.dst   <= dec.dst;
            slot.a     <= rdata_a;
            slot.b     <= rdata_b;
            slot.tgt   <= dec.tgt;
        end
    end

endmodule

// File: rtl/core2_back.sv
module core2_back
    import core2_pkg::*;
(
    input  slot_t              slot,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic               wb_en,
    output logic [RIDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]    wb_val,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic               dmem_we,
    output logic [XLEN-1:0]    dmem_wdata,
    output logic               taken,
    output logic [PC_W-1:0]    target
);

    always_comb begin
        wb_en      = slot.valid && slot.wr;
        wb_idx     = slot.dst;
        wb_val     = (slot.op == OP_ADD) ? slot.a + slot.b : dmem_rdata;
        dmem_addr  = slot.b[DADDR_W-1:0];
        dmem_we    = slot.valid && (slot.op == OP_ST);
        dmem_wdata = slot.a;
        taken      = slot.valid && (slot.op == OP_BZ) && (slot.a == '0);
        target     = slot.tgt;
    end

endmodule

// File: rtl/core2_top.sv
module core2_top
    import core2_pkg::*;
#(
    parameter bit FWD = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [ILEN-1:0]    imem_data,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic               dmem_we,
    output logic [XLEN-1:0]    dmem_wdata,
    input  logic [XLEN-1:0]    dmem_rdata
);

    slot_t             slot;
    logic              stall;
    logic              br_taken;
    logic [PC_W-1:0]   br_target;
    logic              wb_en;
    logic [RIDX_W-1:0] wb_idx;
    logic [XLEN-1:0]   wb_val;
    logic [RIDX_W-1:0] raddr_a, raddr_b;
    logic [XLEN-1:0]   rdata_a, rdata_b;

    core2_regfile #(.FWD(FWD)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wb_en),
        .waddr   (wb_idx),
        .wdata   (wb_val),
        .raddr_a (raddr_a),
        .raddr_b (raddr_b),
        .rdata_a (rdata_a),
        .rdata_b (rdata_b)
    );

    core2_front #(.FWD(FWD)) u_front (
        .clk         (clk),
        .rst         (rst),
        .instr       (imem_data),
        .redirect    (br_taken),
        .redirect_pc (br_target),
        .rdata_a     (rdata_a),
        .rdata_b     (rdata_b),
        .raddr_a     (raddr_a),
        .raddr_b     (raddr_b),
        .pc          (imem_addr),
        .stall       (stall),
        .slot        (slot)
    );

    core2_back u_back (
        .slot       (slot),
        .dmem_rdata (dmem_rdata),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_val     (wb_val),
        .dmem_addr  (dmem_addr),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .taken      (br_taken),
        .target     (br_target)
    );

endmodule

// File: rtl/core2_chk.sv
module core2_chk
    import core2_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] pc,
    input logic            we,
    input logic            taken,
    input logic            stall,
    input logic [PC_W-1:0] tgt,
    input logic            slot_valid
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (pc == '0) && !we);

    // R6
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (!taken && !stall) |=> pc == PC_W'($past(pc) + 1'b1));

    // R6
    slot_refill_chk: assert property (@(posedge clk) disable iff (rst)
        (!taken && !stall) |=> slot_valid);

    // R4
    branch_pc_chk: assert property (@(posedge clk) disable iff (rst)
        taken |=> pc == $past(tgt));

    // R8
    branch_kill_chk: assert property (@(posedge clk) disable iff (rst)
        taken |=> !slot_valid && !we);

endmodule

bind core2_top core2_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc         (imem_addr),
    .we         (dmem_we),
    .taken      (br_taken),
    .stall      (stall),
    .tgt        (br_target),
    .slot_valid (slot.valid)
);

// File: tb/core2_top_bench.sv
`timescale 1ns/1ps
module core2_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [15:0] imem_data;
    logic [7:0]  dmem_addr;
    logic        dmem_we;
    logic [15:0] dmem_wdata;
    logic [15:0] dmem_rdata;

    logic [15:0] imem [256];
    logic [15:0] dmem [256];

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    core2_top u_core2_top (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

    function automatic logic [15:0] i_add(int rd, int ra, int rb);
        return {2'b00, 3'(rd), 3'(ra), 3'(rb), 5'b0};
    endfunction
    function automatic logic [15:0] i_bz(int rc, int t);
        return {2'b01, 3'(rc), 3'b0, 8'(t)};
    endfunction
    function automatic logic [15:0] i_ld(int rd, int ra);
        return {2'b10, 3'(rd), 3'(ra), 8'b0};
    endfunction
    function automatic logic [15:0] i_st(int rv, int ra);
        return {2'b11, 3'(rv), 3'(ra), 8'b0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            summary();
        end
    end

    task automatic clear_mems();
        for (int i = 0; i < 256; i++) begin
            imem[i] = 16'h0000;
            dmem[i] = 16'h0000;
        end
    endtask

    // hold reset, release at a falling edge: that point is cycle 0
    task automatic start();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_straight();
        clear_mems();
        dmem[0] = 16'h0001; dmem[1] = 16'h0020; dmem[2] = 16'hFFFF;
        for (int i = 16'h20; i < 16'h28; i++) dmem[i] = 16'hAAAA;
        imem[0]  = i_ld(1, 0);
        imem[1]  = i_ld(2, 1);
        imem[2]  = i_add(3, 1, 1);
        imem[3]  = i_ld(4, 3);
        imem[4]  = i_add(5, 4, 1);
        imem[5]  = i_add(6, 2, 1);
        imem[6]  = i_st(5, 2);
        imem[7]  = i_add(7, 3, 3);
        imem[8]  = i_st(7, 6);
        imem[9]  = i_add(5, 7, 2);
        imem[10] = i_st(5, 5);
        imem[11] = i_bz(0, 11);
        start();
        for (int k = 0; k < 14; k++) begin
            int exp_pc;
            exp_pc = (k <= 12) ? k : 11;
            if (k <= 11)
                check(imem_addr == 8'(exp_pc), "R6 one fetch per cycle", imem_addr, exp_pc);
            else
                check(imem_addr == 8'(exp_pc), "R4 halt redirect", imem_addr, exp_pc);
            if (k == 6) check(dmem_we == 1'b0, "R3 no write before store", dmem_we, 0);
            if (k == 7) begin
                check(dmem_we == 1'b1, "R3 store write enable", dmem_we, 1);
                check(dmem_addr == 8'h20, "R3 store address", dmem_addr, 8'h20);
                check(dmem_wdata == 16'h0000, "R3 store value", dmem_wdata, 0);
            end
            @(negedge clk);
        end
        repeat (30) @(negedge clk);
        check(dmem[8'h20] == 16'h0000, "R2 add wraps modulo 2^16", dmem[8'h20], 0);
        check(dmem[8'h21] == 16'h0004, "R7 forwarded store address", dmem[8'h21], 4);
        check(dmem[8'h24] == 16'h0024, "R7 forwarded store value and address", dmem[8'h24], 16'h24);
    endtask

    task automatic t_branches();
        clear_mems();
        dmem[0] = 16'h0001; dmem[1] = 16'h0030;
        for (int i = 16'h30; i < 16'h34; i++) dmem[i] = 16'hAAAA;
        imem[0]  = i_ld(1, 0);
        imem[1]  = i_bz(1, 5);
        imem[2]  = i_add(2, 1, 1);
        imem[3]  = i_bz(0, 6);
        imem[4]  = i_add(3, 1, 1);
        imem[5]  = i_add(3, 2, 2);
        imem[6]  = i_ld(5, 1);
        imem[7]  = i_st(3, 5);
        imem[8]  = i_add(6, 5, 1);
        imem[9]  = i_st(2, 6);
        imem[10] = i_add(7, 6, 1);
        imem[11] = i_st(1, 7);
        imem[12] = i_bz(0, 12);
        start();
        for (int k = 0; k < 6; k++) begin
            int exp_pc;
            exp_pc = (k <= 4) ? k : 6;
            if (k == 5)
                check(imem_addr == 8'(exp_pc), "R4 taken branch target", imem_addr, exp_pc);
            else if (k == 2 || k == 3)
                check(imem_addr == 8'(exp_pc), "R5 not-taken keeps sequence", imem_addr, exp_pc);
            else
                check(imem_addr == 8'(exp_pc), "R6 fetch sequence", imem_addr, exp_pc);
            @(negedge clk);
        end
        repeat (30) @(negedge clk);
        check(dmem[8'h30] == 16'h0000, "R8 killed fetch left register zero", dmem[8'h30], 0);
        check(dmem[8'h31] == 16'h0002, "R5 not-taken branch had no effect", dmem[8'h31], 2);
        check(dmem[8'h32] == 16'h0001, "R3 load result stored", dmem[8'h32], 1);
        check(dmem[8'h33] == 16'hAAAA, "R8 no stray store", dmem[8'h33], 16'hAAAA);
    endtask

    task automatic t_loop();
        clear_mems();
        dmem[0] = 16'h0001; dmem[1] = 16'hFFFF; dmem[2] = 16'h0003; dmem[3] = 16'h0040;
        dmem[8'h40] = 16'hAAAA;
        imem[0]  = i_ld(1, 0);
        imem[1]  = i_ld(2, 1);
        imem[2]  = i_add(3, 1, 1);
        imem[3]  = i_ld(4, 3);
        imem[4]  = i_add(5, 3, 1);
        imem[5]  = i_ld(6, 5);
        imem[6]  = i_bz(4, 10);
        imem[7]  = i_add(7, 7, 1);
        imem[8]  = i_add(4, 4, 2);
        imem[9]  = i_bz(0, 6);
        imem[10] = i_st(7, 6);
        imem[11] = i_bz(0, 11);
        start();
        repeat (60) @(negedge clk);
        check(dmem[8'h40] == 16'h0003, "R4 loop count via branches", dmem[8'h40], 3);
    endtask

    task automatic t_reset();
        // core is spinning at a non-zero address here
        check(imem_addr != 8'h00, "R1 precondition non-zero pc", imem_addr, 1);
        rst = 1'b1;
        @(negedge clk);
        check(imem_addr == 8'h00, "R1 pc cleared in reset", imem_addr, 0);
        check(dmem_we == 1'b0, "R1 no write in reset", dmem_we, 0);
        rst = 1'b0;
        check(imem_addr == 8'h00, "R1 pc zero after reset", imem_addr, 0);
    endtask

    task automatic t_reg_clear();
        // registers read zero after reset: storing r3 to r0's address writes 0
        clear_mems();
        dmem[0] = 16'h5555;
        imem[0] = i_st(3, 0);
        imem[1] = i_bz(0, 1);
        start();
        repeat (6) @(negedge clk);
        check(dmem[0] == 16'h0000, "R1 registers zero after reset", dmem[0], 0);
    endtask

    initial begin
        clear_mems();
        t_straight();
        t_branches();
        t_loop();
        t_reset();
        t_reg_clear();
        summary();
    end

endmodule